// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects single-cycle event pulses from a streaming packet FIFO into a 32-bit status register of sticky bits. Once an event sets its bit, the bit stays set until software clears it by writing a 1 to it. A matching enable register selects which pending bits may drive the single active-high interrupt output.

Most sources arrive as input pulses: threshold flags, ECC detections, reset-complete notices, packet completion and packet errors. One source is built in. A transmit size checker counts the data words written for the current packet, where a partial word counts as a whole one. When software writes the packet's byte length, the checker compares that count with the byte length divided by the word size and rounded up. A mismatch sets the size-error bit.

Software reaches the registers through a plain register port with address, write data, write strobe and read strobe. The status register is at offset 0x0, the enable register at 0x4, and the transmit length register at 0x8.

Top module: `irq_status_ctrl`

## Requirements
- R1: A pulse on an event input sets its status bit on the next clock edge. The bit then stays 1 with no further event until software clears it.
- R2: A write to offset 0x0 clears every status bit whose write-data bit is 1. A write-data bit of 0 leaves its status bit unchanged, and writing 1 to a status bit that is already 0 leaves it at 0.
- R3: One write to offset 0x0 can clear several status bits at once.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit is 1 afterwards.
- R5: `irq` is 1 exactly when some status bit and the enable bit at the same position are both 1. The enable register is read/write at offset 0x4, holds bits 31:15 and resets to zero.
- R6: Bits 14:0 of the status and enable registers always read 0, including after a write of all ones.
- R7: After reset the status register reads 0x01D00000, so bits 20, 22, 23 and 24 are 1 and all other bits are 0.
- R8: Event input `evt_i[k]` sets status bit 15+k for k = 0..16. Bit 25 (k = 10) is also set by the size checker.
- R9: A write to offset 0x8 ends a packet. Its length L is taken from `wdata[LEN_W-1:0]`. Status bit 25 is set when the number of `tx_word` pulses since the previous length write differs from ceil(L / WORD_BYTES). A `tx_word` pulse in the same cycle as the length write counts toward the packet being ended. Differences of bytes inside the last word do not set the bit.
- R10: Read data appears on `rdata` on the clock edge where `re` is 1 and holds until the next read. Reads of offset 0x8 and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 17 | Event pulses; bit k sets status bit 15+k |
| tx_word | input | 1 | One transmit data word (full or partial) written this cycle |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench targets a clearing write and an event that land on the same bit in the same cycle. A design that let the clear win would silently drop that event. It writes zeros and writes ones onto bits that are already clear, which catches a design that toggles bits or clears the wrong ones. The bench also checks the irregular reset pattern, which a design that resets everything to zero would fail. The size checker is driven with lengths that fall exactly on a word boundary, lengths one byte past a boundary, a zero length, and a word written in the same cycle as the length. A wrong rounding or an off-by-one in the word count would raise a false size error or miss a real one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W   = 32;
  localparam int RSV_W    = 15;                 // reserved low bits
  localparam int NSTAT    = DATA_W - RSV_W;     // implemented status bits
  localparam int OFF_STAT = 'h0;
  localparam int OFF_ENA  = 'h4;
  localparam int OFF_LEN  = 'h8;
  localparam int BIT_SIZE = 25;                 // size-error status bit
  localparam logic [DATA_W-1:0] STAT_RST = 32'h01D0_0000;

  // number of whole words needed to carry len bytes, 2**lg bytes per word
  function automatic logic [31:0] ceil_words(input logic [31:0] len,
                                             input int unsigned lg);
    logic [31:0] pad;
    pad = (32'd1 << lg) - 32'd1;
    return (len + pad) >> lg;
  endfunction
endpackage

// File: rtl/irq_size_check.sv
module irq_size_check #(
  parameter int LEN_W = 16,
  parameter int WB_LG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_wr,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  output logic             size_err
);
  import irq_pkg::*;

  logic [LEN_W:0] cnt_q;
  logic [LEN_W:0] cnt_now;
  logic [31:0]    words_exp;
  logic           len_mismatch;

  assign cnt_now      = cnt_q + {{LEN_W{1'b0}}, word_wr};
  assign words_exp    = ceil_words(32'(len_val), WB_LG);
  assign len_mismatch = 32'(cnt_now) != words_exp;
  assign size_err     = len_wr && len_mismatch;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (len_wr)  cnt_q <= '0;
    else if (word_wr) cnt_q <= cnt_now;
  end

  // R9: an error pulse only ever comes with a length write
  a_r9_err_on_len_write: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> len_wr);
  // R9: the word count starts afresh after each length write
  a_r9_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr |=> cnt_q == '0);
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int                N   = 17,
  parameter logic [N-1:0]      RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      stat[i] <= RST[i];
      else if (set[i]) stat[i] <= 1'b1;
      else if (clr[i]) stat[i] <= 1'b0;
    end

    // R1: a set bit stays set unless cleared
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !clr[i]) |=> stat[i]);
    // R4: an event is never lost to a simultaneous clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> stat[i]);
    // R2: a clear with no event empties the bit
    a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !stat[i]);
    // R2: a bit that is 0 does not rise without an event
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat[i] && !set[i]) |=> !stat[i]);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int ADDR_W     = 4,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [16:0]               evt_i,
  input  logic                      tx_word,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [irq_pkg::DATA_W-1:0] wdata,
  input  logic                      we,
  input  logic                      re,
  output logic [irq_pkg::DATA_W-1:0] rdata,
  output logic                      irq
);
  import irq_pkg::*;

  localparam int WB_LG  = $clog2(WORD_BYTES);
  localparam int SZ_IDX = BIT_SIZE - RSV_W;
  localparam logic [NSTAT-1:0] BANK_RST = STAT_RST[DATA_W-1:RSV_W];

  logic             sel_stat, sel_ena, sel_len;
  logic             len_wr, size_err;
  logic [NSTAT-1:0] ev_set, ev_clr, stat, ena_q;
  logic [DATA_W-1:0] stat_word, ena_word;

  assign sel_stat = addr == ADDR_W'(OFF_STAT);
  assign sel_ena  = addr == ADDR_W'(OFF_ENA);
  assign sel_len  = addr == ADDR_W'(OFF_LEN);
  assign len_wr   = we && sel_len;

  irq_size_check #(.LEN_W(LEN_W), .WB_LG(WB_LG)) u_size (
    .clk(clk), .rst_n(rst_n), .word_wr(tx_word), .len_wr(len_wr),
    .len_val(wdata[LEN_W-1:0]), .size_err(size_err)
  );

  assign ev_set = evt_i | (NSTAT'(size_err) << SZ_IDX);
  assign ev_clr = (we && sel_stat) ? wdata[DATA_W-1:RSV_W] : '0;

  irq_sticky_bank #(.N(NSTAT), .RST(BANK_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             ena_q <= '0;
    else if (we && sel_ena) ena_q <= wdata[DATA_W-1:RSV_W];
  end

  assign stat_word = {stat, {RSV_W{1'b0}}};
  assign ena_word  = {ena_q, {RSV_W{1'b0}}};
  assign irq       = |(stat & ena_q);

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (re) begin
      if (sel_stat)     rdata <= stat_word;
      else if (sel_ena) rdata <= ena_word;
      else              rdata <= '0;
    end
  end

  // R6: reserved bits read zero after any status read
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(re) |-> rdata[RSV_W-1:0] == '0);
  // R10: rdata is only updated by a read
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
  // R9: a size mismatch always lands in its status bit
  a_r9_size_bit: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> stat[SZ_IDX]);
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  localparam int WB = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] evt_i = '0;
  logic        tx_word = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_ctrl #(.ADDR_W(4), .LEN_W(16), .WORD_BYTES(WB)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .tx_word(tx_word), .addr(addr),
    .wdata(wdata), .we(we), .re(re), .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [16:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); check("R7 reset status", d, 32'h01D0_0000);
    rd(4'h4, d); check("R5 reset enable", d, 32'h0);
    check("R5 reset irq", {31'b0, irq}, 32'h0);
    rd(4'h8, d); check("R10 length reads zero", d, 32'h0);
    rd(4'hC, d); check("R10 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R2 write zero no effect", d, 32'h01D0_0000);
    wr(4'h0, 32'h01D0_0000);
    rd(4'h0, d); check("R3 multi-bit clear", d, 32'h0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    pulse(17'h00001);
    pulse(17'h10000);
    repeat (5) @(negedge clk);
    rd(4'h0, d); check("R1 R8 sticky bits 15 and 31", d, 32'h8000_8000);
    wr(4'h0, 32'h0010_0000);
    rd(4'h0, d); check("R2 one onto zero bit", d, 32'h8000_8000);
    wr(4'h0, 32'h0000_8000);
    rd(4'h0, d); check("R2 clear bit 15 only", d, 32'h8000_0000);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    check("R5 irq masked", {31'b0, irq}, 32'h0);
    wr(4'h4, 32'h8000_0000);
    check("R5 irq enabled", {31'b0, irq}, 32'h1);
    rd(4'h4, d); check("R5 enable readback", d, 32'h8000_0000);
    wr(4'h0, 32'h8000_0000);
    check("R5 irq after clear", {31'b0, irq}, 32'h0);
    wr(4'h4, 32'h0001_0000);
    pulse(17'h00004);
    check("R5 irq other bit", {31'b0, irq}, 32'h0);
    wr(4'h4, 32'h0002_0000);
    check("R5 irq matching bit", {31'b0, irq}, 32'h1);
    wr(4'h0, 32'h0002_0000);
    wr(4'h4, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk); evt_i = 17'h01000; addr = 4'h0; wdata = 32'h0800_0000; we = 1'b1;
    @(negedge clk); evt_i = '0; we = 1'b0;
    rd(4'h0, d); check("R4 set wins over clear", d, 32'h0800_0000);
    wr(4'h0, 32'h0800_0000);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R10 unmapped write ignored", d, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R6 enable reserved zero", d, 32'hFFFF_8000);
    wr(4'h4, 32'h0);
  endtask

  task automatic t_pkt(input int words, input int len, input bit same);
    logic [31:0] d;
    int exp_w;
    exp_w = (len + WB - 1) / WB;
    for (int i = 0; i < words - (same ? 1 : 0); i++) begin
      @(negedge clk); tx_word = 1'b1;
      @(negedge clk); tx_word = 1'b0;
    end
    @(negedge clk); addr = 4'h8; wdata = 32'(len); we = 1'b1; tx_word = same;
    @(negedge clk); we = 1'b0; tx_word = 1'b0;
    rd(4'h0, d);
    check($sformatf("R9 size words=%0d len=%0d", words, len), d,
          (words != exp_w) ? 32'h0200_0000 : 32'h0);
    wr(4'h0, 32'h0200_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_clear;
    t_sticky;
    t_irq;
    t_set_wins;
    t_reserved;
    t_pkt(3, 10, 0);
    t_pkt(3, 13, 0);
    t_pkt(2, 8, 0);
    t_pkt(2, 9, 0);
    t_pkt(0, 0, 0);
    t_pkt(1, 0, 0);
    t_pkt(3, 12, 1);
    t_pkt(4, 12, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule